// File: doc/BRIEF.md
# Spare-Extended SEC-DED Memory Codec

This block protects a 16-bit memory word with a single-error-correcting, double-error-detecting code whose base part is an odd-column-weight code with six check bits. Up to three further check bits can be kept in spare memory columns that the repair step left idle. Each stored extra bit adds one row to the parity-check matrix. The extra rows only take part in decoding while their spare is free. They give the decoder more syndrome bits, so fewer triple errors are mistaken for single errors.

The encoder path turns write data into nine check bits. Bits 5:0 are the base code and bit 6+j is the extra bit for spare j. The decoder path takes the read word, the nine stored check bits and a mask that marks each spare as taken by repair. It recomputes the check bits from the read data and XORs them with the stored ones. It then drops the syndrome bits of taken spares and compares the rest with every code column. A match flips the matching data bit, or flags a corrected check bit. A nonzero syndrome that matches nothing is reported as uncorrectable. Both paths are purely combinational.

Top module: `secded_spare_codec`

## Requirements
- R1: The check bits from `wr_chk` for any `wr_data`, stored unchanged with any spare mask, decode with both flags low and `rd_fixed` equal to the data.
- R2: Whenever the active syndrome is zero, `rd_fixed` equals `rd_data` and neither flag is raised.
- R3: A single flipped data bit is restored in `rd_fixed`, with `err_corr`=1 and `err_fatal`=0, under every spare mask.
- R4: A single flipped base check bit (`rd_chk[5:0]`) or a flipped extra bit `rd_chk[6+j]` of a free spare leaves `rd_fixed` equal to the written data, with `err_corr`=1 and `err_fatal`=0.
- R5: Any two flipped bits among the data bits, the base check bits and the free extra bits give `err_fatal`=1 and `err_corr`=0. On `err_fatal`, `rd_fixed` equals `rd_data`.
- R6: When `spare_used[j]`=1, the value of `rd_chk[6+j]` has no effect on any output.
- R7: `err_corr` and `err_fatal` are never high together.
- R8: Consider triple errors confined to the 16 data bits and the 6 base check bits, where a miscorrection is a report of `err_corr`=1. A mask whose free spares are a superset of another mask's free spares never has more such miscorrections than that other mask.
- R9: Any three flipped active bits raise at least one flag. With all spares taken (`spare_used`=3'b111), the block works as a plain SEC-DED decoder under R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_data | input | 16 | Data word to encode |
| wr_chk | output | 9 | Check bits for wr_data: [5:0] base, [8:6] extra |
| rd_data | input | 16 | Data word read from memory |
| rd_chk | input | 9 | Check bits read from memory, same layout as wr_chk |
| spare_used | input | 3 | Bit j high: spare j is taken by repair, rd_chk[6+j] ignored |
| rd_fixed | output | 16 | Corrected read data |
| err_corr | output | 1 | A single error was found and corrected |
| err_fatal | output | 1 | Nonzero syndrome matching no code column |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies on either path. The bench applies write data on a falling clock edge, waits a short settling delay, and reads `wr_chk`. It then drives the read-side inputs and samples `rd_fixed` and both flags after a second settling delay, still well before the next rising edge. Miscorrection counts are built up per spare mask over the whole pattern sweep and compared only after every mask is done.

// File: rtl/secded_spare_codec.sv
module secded_spare_codec #(
  parameter int DW = 16,
  parameter int BW = 6,
  parameter int XW = 3
) (
  input  logic [DW-1:0]    wr_data,
  output logic [BW+XW-1:0] wr_chk,
  input  logic [DW-1:0]    rd_data,
  input  logic [BW+XW-1:0] rd_chk,
  input  logic [XW-1:0]    spare_used,
  output logic [DW-1:0]    rd_fixed,
  output logic             err_corr,
  output logic             err_fatal
);
  localparam int CW = BW + XW;

  // Data column n: base part is the n-th odd value of weight >= 3; extra part is a mixing of n.
  function automatic logic [DW*CW-1:0] build_h();
    logic [DW*CW-1:0] t;
    int n;
    t = '0;
    n = 0;
    for (int v = 1; v < (1 << BW); v++) begin
      if (($countones(v) % 2 == 1) && ($countones(v) >= 3) && (n < DW)) begin
        t[n*CW +: BW] = BW'(v);
        t[n*CW+BW +: XW] = XW'((n * 3 + 1) ^ (n >> 2));
        n++;
      end
    end
    return t;
  endfunction

  localparam logic [DW*CW-1:0] HTAB = build_h();

  logic [CW-1:0] enc, rec, act, syn;
  logic [DW-1:0] hit;
  logic          chk_hit;

  always_comb begin
    enc = '0;
    rec = '0;
    for (int r = 0; r < CW; r++)
      for (int i = 0; i < DW; i++) begin
        enc[r] = enc[r] ^ (wr_data[i] & HTAB[i*CW+r]);
        rec[r] = rec[r] ^ (rd_data[i] & HTAB[i*CW+r]);
      end
  end

  assign wr_chk = enc;
  assign act    = {~spare_used, {BW{1'b1}}};
  assign syn    = (rec ^ rd_chk) & act;

  always_comb begin
    hit = '0;
    for (int i = 0; i < DW; i++)
      hit[i] = (syn == (HTAB[i*CW +: CW] & act));
    chk_hit = 1'b0;
    for (int j = 0; j < CW; j++)
      if (act[j] && syn == (CW'(1) << j)) chk_hit = 1'b1;
  end

  assign rd_fixed  = rd_data ^ (syn != '0 ? hit : '0);
  assign err_corr  = (syn != '0) && ((|hit) || chk_hit);
  assign err_fatal = (syn != '0) && !((|hit) || chk_hit);

  always_comb begin
    assert_flags_exclusive_R7: assert (!(err_corr && err_fatal));
    assert_quiet_on_zero_R2: assert ((syn != '0) || (rd_fixed == rd_data && !err_corr && !err_fatal));
    assert_no_flip_on_fatal_R5: assert (!err_fatal || rd_fixed == rd_data);
    assert_single_flip_R3: assert ($countones(rd_fixed ^ rd_data) <= 1);
    assert_odd_base_flagged_R9: assert (!(^syn[BW-1:0]) || err_corr || err_fatal);
  end
endmodule

// File: tb/tb_secded_spare_codec.sv
module tb_secded_spare_codec;
  logic        clk = 1'b0;
  logic [15:0] wr_data, rd_data, rd_fixed;
  logic [8:0]  wr_chk, rd_chk;
  logic [2:0]  spare_used;
  logic        err_corr, err_fatal;
  int total = 0, bad = 0, cyc = 0;
  int mc [8];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  secded_spare_codec dut (
    .wr_data(wr_data), .wr_chk(wr_chk), .rd_data(rd_data), .rd_chk(rd_chk),
    .spare_used(spare_used), .rd_fixed(rd_fixed), .err_corr(err_corr), .err_fatal(err_fatal)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: cycles=%0d expected<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // [29:27] used mask, [26:11] data flips, [10:2] check flips, [1] exp corr, [0] exp fatal
  localparam logic [29:0] VEC [10] = '{
    {3'b000, 16'h0000, 9'h000, 2'b00},
    {3'b111, 16'h0000, 9'h000, 2'b00},
    {3'b000, 16'h0001, 9'h000, 2'b10},
    {3'b111, 16'h8000, 9'h000, 2'b10},
    {3'b000, 16'h0000, 9'h008, 2'b10},
    {3'b000, 16'h0000, 9'h100, 2'b10},
    {3'b100, 16'h0000, 9'h100, 2'b00},
    {3'b000, 16'h0003, 9'h000, 2'b01},
    {3'b111, 16'h0020, 9'h001, 2'b01},
    {3'b001, 16'h0000, 9'h0C0, 2'b10}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] d, input logic [15:0] df, input logic [8:0] cf, input logic [2:0] m);
    @(negedge clk);
    wr_data = d;
    #0.5;
    rd_data = d ^ df;
    rd_chk = wr_chk ^ cf;
    spare_used = m;
    #0.5;
  endtask

  function automatic void flip_pos(input int p, inout logic [15:0] df, inout logic [8:0] cf);
    if (p < 16) df[p] = ~df[p];
    else cf[p-16] = ~cf[p-16];
  endfunction

  function automatic bit active(input int p, input logic [2:0] m);
    return (p < 22) || !m[p-22];
  endfunction

  initial begin
    wr_data = '0; rd_data = '0; rd_chk = '0; spare_used = '0;
    for (int k = 0; k < 8; k++) mc[k] = 0;
    #1;
    check(rd_fixed == 16'h0 && !err_corr && !err_fatal, "R2 idle", {rd_fixed, 14'b0, err_corr, err_fatal}, 32'h0);

    for (int k = 0; k < 10; k++) begin
      logic [15:0] d;
      d = 16'hA5C3 ^ 16'(k * 16'h1357);
      apply(d, VEC[k][26:11], VEC[k][10:2], VEC[k][29:27]);
      check({err_corr, err_fatal} == VEC[k][1:0], $sformatf("R1/R4/R5/R6 vec%0d flags", k), {30'b0, err_corr, err_fatal}, {30'b0, VEC[k][1:0]});
      if (!VEC[k][0])
        check(rd_fixed == d, $sformatf("R3/R6 vec%0d data", k), rd_fixed, d);
    end

    for (int mi = 0; mi < 8; mi++) begin
      logic [2:0] m;
      m = 3'(mi);
      for (int a = 0; a < 25; a++) begin
        if (!active(a, m)) continue;
        begin
          logic [15:0] df; logic [8:0] cf;
          df = '0; cf = '0;
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          apply(lfsr, 16'h0, 9'h0, m);
          check(!err_corr && !err_fatal && rd_fixed == lfsr, "R1 clean", {rd_fixed, 14'b0, err_corr, err_fatal}, {lfsr, 16'h0});
          flip_pos(a, df, cf);
          apply(lfsr, df, cf, m);
          check(err_corr && !err_fatal && rd_fixed == lfsr, a < 16 ? "R3 single data" : "R4 single check",
                {rd_fixed, 14'b0, err_corr, err_fatal}, {lfsr, 16'h0002});
          for (int j = 0; j < 3; j++)
            if (m[j]) begin
              logic [8:0] cf2;
              cf2 = cf;
              cf2[6+j] = ~cf2[6+j];
              apply(lfsr, df, cf2, m);
              check(err_corr && !err_fatal && rd_fixed == lfsr, "R6 ignored spare bit",
                    {rd_fixed, 14'b0, err_corr, err_fatal}, {lfsr, 16'h0002});
            end
        end
        for (int b = a + 1; b < 25; b++) begin
          if (!active(b, m)) continue;
          begin
            logic [15:0] df; logic [8:0] cf;
            df = '0; cf = '0;
            flip_pos(a, df, cf); flip_pos(b, df, cf);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply(lfsr, df, cf, m);
            check(err_fatal && !err_corr && rd_fixed == (lfsr ^ df), "R5 double",
                  {rd_fixed, 14'b0, err_corr, err_fatal}, {lfsr ^ df, 16'h0001});
          end
          for (int c = b + 1; c < 25; c++) begin
            if (!active(c, m)) continue;
            begin
              logic [15:0] df; logic [8:0] cf;
              df = '0; cf = '0;
              flip_pos(a, df, cf); flip_pos(b, df, cf); flip_pos(c, df, cf);
              apply(lfsr, df, cf, m);
              check(err_corr || err_fatal, "R9 triple flagged", {30'b0, err_corr, err_fatal}, 32'h1);
              check(!(err_corr && err_fatal), "R7 exclusive", {30'b0, err_corr, err_fatal}, 32'h1);
              if (c < 22 && err_corr) mc[mi]++;
            end
          end
        end
      end
    end

    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        if (a != b && ((a & ~b) == 0))
          check(mc[a] <= mc[b], $sformatf("R8 mask%0d vs mask%0d", a, b), mc[a], mc[b]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule